// File: doc/BRIEF.md
# Four-Bank DRAM Command Timing Checker

This block watches the command bus of a four-bank double-data-rate SDRAM and judges every command against the row and column timing rules of the memory, all limits expressed as whole clock cycles and set through parameters. It follows each bank through idle, open-row and recovery phases. It also keeps the cross-bank timers: activate-to-activate spacing, the write-to-read gap, the settle time after a mode write, and the age of the last refresh.

It sits beside a memory controller, or in a verification environment, and receives the already decoded command, the bank address and the auto-precharge bit. Each rule has its own sticky violation flag. Next to each flag sits the bank that first broke the rule. A command that breaks a rule still acts on the tracked bank state, so one error does not set off a chain of follow-on reports.

Top module: `dram_timing_checker`

## Requirements
- R1: Commands are coded on `cmd_i` as 0 no-op, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 auto-refresh, 7 mode write. Bank n reports its state on `bank_state_o[2n+1:2n]` as 0 idle, 1 row open, 2 recovering. A precharge of an open bank keeps it recovering for TRP cycles. A write with auto-precharge keeps it recovering for BURST+TDAL cycles. A refresh keeps every bank recovering for TRFC cycles.
- R2: Violation k sets bit k of `viol_o` one cycle after the offending command. The bit then stays set until reset. Field `viol_bank_o[2k+1:2k]` keeps the bank of the first offence; when several banks offend in the same cycle, the lowest bank number is kept. A sequence that keeps every rule raises no flag.
- R3: Bit 0 (protocol) is set by any of these: an activate to an open bank, a read or write to a bank that is not open, or a refresh or mode write while any bank is open.
- R4: Bit 1 is set by a read or write fewer than TRCD cycles after the activate of the same bank.
- R5: Bit 2 is set by a precharge, single or all, fewer than TRAS cycles after that bank's activate. Bit 8 is set once a row has stayed open for more than TRAS_MAX cycles.
- R6: Bit 3 is set by an activate, refresh or mode write that meets a bank still in precharge recovery. Bit 4 is set by an activate fewer than TRC cycles after the previous activate of the same bank.
- R7: Bit 5 is set by a precharge of an open bank fewer than BURST+TWR cycles after its last write command.
- R8: Bit 6 is set by an activate, refresh or mode write that meets a bank that is still recovering from a write with auto-precharge.
- R9: Bit 7 is set by an activate, refresh or mode write fewer than TRFC cycles after a refresh.
- R10: Bit 9 is set by an activate fewer than TRRD cycles after any earlier activate. The bank recorded is the bank of the late activate.
- R11: Bit 10 is set by any command other than no-op fewer than TMRD cycles after a mode write.
- R12: Bit 11 is set by a read fewer than BURST+TCDLR cycles after any write command. This also catches a read that cuts into a write burst.
- R13: Bit 12 is set when more than TREFI cycles pass without a refresh.
- R14: After reset every bank is idle and `viol_o` and `viol_bank_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| cmd_i | input | 3 | Decoded command code (R1) |
| bank_i | input | 2 | Bank addressed by the command |
| ap_i | input | 1 | Auto-precharge request for read and write |
| bank_state_o | output | 8 | Two-bit state per bank |
| viol_o | output | 13 | Sticky violation flags, one per rule |
| viol_bank_o | output | 26 | Two-bit bank of the first offence per rule |

## Verification
The bound checker checks the following on every cycle: flags and their recorded banks never change once set, no bank reaches an unused state code, an idle bank stays idle unless it is activated or refreshed, a read or write to an idle bank raises the protocol flag, and an early activate raises the activate-spacing flag, measured by a counter kept in the checker. The exact cycle at which each per-bank and cross-bank limit begins to be met is shown only by the bench. It sweeps the gap between command pairs across each threshold, with a small configuration that separates TRC from TRAS+TRP. The bench also shows which bank is recorded when several banks offend together and how long each recovery phase lasts.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_RECOV = 2'd2
  } bank_st_e;

  // why a bank is recovering: decides which flag a premature command raises
  typedef enum logic [1:0] {
    RSN_PRE = 2'd0,
    RSN_DAL = 2'd1,
    RSN_RFC = 2'd2
  } rsn_e;

  localparam int NVIOL    = 13;
  localparam int V_PROTO  = 0;
  localparam int V_RCD    = 1;
  localparam int V_RASMIN = 2;
  localparam int V_RP     = 3;
  localparam int V_RC     = 4;
  localparam int V_WR     = 5;
  localparam int V_DAL    = 6;
  localparam int V_RFC    = 7;
  localparam int V_RASMAX = 8;
  localparam int V_RRD    = 9;
  localparam int V_MRD    = 10;
  localparam int V_WTR    = 11;
  localparam int V_REFI   = 12;

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dtc_bank.sv
module dtc_bank
  import dtc_pkg::*;
#(
  parameter int TRCD     = 5,
  parameter int TRAS     = 10,
  parameter int TRAS_MAX = 100000,
  parameter int TRP      = 5,
  parameter int TRC      = 15,
  parameter int TWR      = 3,
  parameter int TDAL     = 8,
  parameter int TRFC     = 17,
  parameter int BURST    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             rd,
  input  logic             wr,
  input  logic             pre,
  input  logic             ref_all,
  input  logic             mrs,
  input  logic             ap,
  output logic [1:0]       state_o,
  output logic [NVIOL-1:0] hit_o
);

  localparam int LMAX = maxi(maxi(TRFC, BURST + TDAL), maxi(TRC, BURST + TWR + TRP));
  localparam int CW   = $clog2(LMAX + 1);
  localparam int RW   = $clog2(TRAS_MAX + 2);

  bank_st_e        st_q, st_d;
  rsn_e            rsn_q, rsn_d;
  logic [CW-1:0]   rcd_q, rcd_d, rc_q, rc_d, rp_q, rp_d, wr_q, wr_d;
  logic [RW-1:0]   ras_q, ras_d;
  logic            rec_go;
  logic [CW-1:0]   rec_len;
  rsn_e            rec_rsn;
  logic            is_open, is_recov, busy_hit;

  function automatic logic [CW-1:0] dn(input logic [CW-1:0] x);
    return (x == '0) ? x : x - 1'b1;
  endfunction

  assign is_open  = (st_q == BK_OPEN);
  assign is_recov = (st_q == BK_RECOV);

  // next-state: counters count down to zero; a command reloads them
  always_comb begin
    rcd_d   = dn(rcd_q);
    rc_d    = dn(rc_q);
    wr_d    = dn(wr_q);
    rp_d    = dn(rp_q);
    rsn_d   = rsn_q;
    ras_d   = (is_open && ras_q != RW'(TRAS_MAX + 1)) ? ras_q + 1'b1 : ras_q;
    st_d    = (is_recov && rp_d == '0) ? BK_IDLE : st_q;
    rec_go  = 1'b0;
    rec_len = '0;
    rec_rsn = RSN_PRE;
    if (act) begin
      st_d  = BK_OPEN;
      rcd_d = CW'(TRCD - 1);
      rc_d  = CW'(TRC - 1);
      ras_d = RW'(1);
      wr_d  = '0;
    end else if (wr && is_open) begin
      wr_d = CW'(BURST + TWR - 1);
      if (ap) begin
        rec_go  = 1'b1;
        rec_len = CW'(BURST + TDAL - 1);
        rec_rsn = RSN_DAL;
      end
    end else if (rd && is_open && ap) begin
      rec_go  = 1'b1;
      rec_len = CW'(BURST + TRP - 1);
      rec_rsn = RSN_PRE;
    end else if (pre && is_open) begin
      rec_go  = 1'b1;
      rec_len = CW'(TRP - 1);
      rec_rsn = RSN_PRE;
    end else if (ref_all) begin
      rec_go  = 1'b1;
      rec_len = CW'(TRFC - 1);
      rec_rsn = RSN_RFC;
    end
    if (rec_go) begin
      rp_d  = rec_len;
      rsn_d = rec_rsn;
      st_d  = (rec_len == '0) ? BK_IDLE : BK_RECOV;
    end
  end

  // rule evaluation against the state seen by the current command
  always_comb begin
    hit_o           = '0;
    busy_hit        = (act || ref_all || mrs) && is_recov;
    hit_o[V_PROTO]  = (act && is_open) || ((rd || wr) && !is_open) ||
                      ((ref_all || mrs) && is_open);
    hit_o[V_RCD]    = (rd || wr) && is_open && (rcd_q != '0);
    hit_o[V_RASMIN] = pre && is_open && (ras_q < RW'(TRAS));
    hit_o[V_RP]     = busy_hit && (rsn_q == RSN_PRE);
    hit_o[V_DAL]    = busy_hit && (rsn_q == RSN_DAL);
    hit_o[V_RFC]    = busy_hit && (rsn_q == RSN_RFC);
    hit_o[V_RC]     = act && (rc_q != '0);
    hit_o[V_WR]     = pre && is_open && (wr_q != '0);
    hit_o[V_RASMAX] = is_open && (ras_q > RW'(TRAS_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      rsn_q <= RSN_PRE;
      rcd_q <= '0;
      rc_q  <= '0;
      rp_q  <= '0;
      wr_q  <= '0;
      ras_q <= '0;
    end else begin
      st_q  <= st_d;
      rsn_q <= rsn_d;
      rcd_q <= rcd_d;
      rc_q  <= rc_d;
      rp_q  <= rp_d;
      wr_q  <= wr_d;
      ras_q <= ras_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/dtc_global.sv
module dtc_global
  import dtc_pkg::*;
#(
  parameter int TRRD  = 2,
  parameter int TMRD  = 2,
  parameter int TCDLR = 2,
  parameter int BURST = 2,
  parameter int TREFI = 2145
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  output logic [NVIOL-1:0] hit_o
);

  localparam int GMAX = maxi(maxi(TRRD, TMRD), BURST + TCDLR);
  localparam int GW   = $clog2(GMAX + 1);
  localparam int FW   = $clog2(TREFI + 2);

  logic [GW-1:0] rrd_q, rrd_d, mrd_q, mrd_d, wtr_q, wtr_d;
  logic [FW-1:0] refi_q, refi_d;
  logic          refi_en;

  function automatic logic [GW-1:0] dn(input logic [GW-1:0] x);
    return (x == '0) ? x : x - 1'b1;
  endfunction

  assign refi_en = (cmd == CMD_REF) || (refi_q != FW'(TREFI + 1));

  always_comb begin
    rrd_d  = (cmd == CMD_ACT) ? GW'(TRRD - 1) : dn(rrd_q);
    mrd_d  = (cmd == CMD_MRS) ? GW'(TMRD - 1) : dn(mrd_q);
    wtr_d  = (cmd == CMD_WR)  ? GW'(BURST + TCDLR - 1) : dn(wtr_q);
    refi_d = (cmd == CMD_REF) ? FW'(1) : refi_q + 1'b1;
  end

  always_comb begin
    hit_o         = '0;
    hit_o[V_RRD]  = (cmd == CMD_ACT) && (rrd_q != '0);
    hit_o[V_MRD]  = (cmd != CMD_NOP) && (mrd_q != '0);
    hit_o[V_WTR]  = (cmd == CMD_RD) && (wtr_q != '0);
    hit_o[V_REFI] = (refi_q > FW'(TREFI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q  <= '0;
      mrd_q  <= '0;
      wtr_q  <= '0;
      refi_q <= '0;
    end else begin
      rrd_q <= rrd_d;
      mrd_q <= mrd_d;
      wtr_q <= wtr_d;
      if (refi_en) refi_q <= refi_d;
    end
  end

endmodule

// File: rtl/dtc_flags.sv
module dtc_flags
  import dtc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NBANK-1:0][NVIOL-1:0] bank_hit,
  input  logic [NVIOL-1:0]            glob_hit,
  input  logic [BW-1:0]               cmd_bank,
  output logic [NVIOL-1:0]            viol_o,
  output logic [NVIOL*BW-1:0]         viol_bank_o
);

  logic [NVIOL-1:0]         flag_q, flag_d;
  logic [NVIOL-1:0][BW-1:0] who_q, who_d;

  for (genvar k = 0; k < NVIOL; k++) begin : g_kind
    logic          any;
    logic [BW-1:0] who;
    always_comb begin
      any = glob_hit[k];
      who = (k == V_REFI) ? '0 : cmd_bank;
      for (int b = NBANK - 1; b >= 0; b--) begin
        if (bank_hit[b][k]) begin
          any = 1'b1;
          who = BW'(b);
        end
      end
      flag_d[k] = flag_q[k] | any;
      who_d[k]  = (!flag_q[k] && any) ? who : who_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      who_q  <= '0;
    end else begin
      flag_q <= flag_d;
      who_q  <= who_d;
    end
  end

  assign viol_o      = flag_q;
  assign viol_bank_o = who_q;

endmodule

// File: rtl/dram_timing_checker.sv
module dram_timing_checker
  import dtc_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int TRCD     = 5,
  parameter int TRAS     = 10,
  parameter int TRAS_MAX = 100000,
  parameter int TRP      = 5,
  parameter int TRC      = 15,
  parameter int TRRD     = 2,
  parameter int TWR      = 3,
  parameter int TDAL     = 8,
  parameter int TRFC     = 17,
  parameter int TCDLR    = 2,
  parameter int TMRD     = 2,
  parameter int BURST    = 2,
  parameter int TREFI    = 2145,
  localparam int BW      = $clog2(NBANK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd_i,
  input  logic [BW-1:0]       bank_i,
  input  logic                ap_i,
  output logic [2*NBANK-1:0]  bank_state_o,
  output logic [NVIOL-1:0]    viol_o,
  output logic [NVIOL*BW-1:0] viol_bank_o
);

  logic [1:0]                  rs_q;
  logic                        rst_q_n;
  cmd_e                        cmd;
  logic [NBANK-1:0][NVIOL-1:0] bank_hit;
  logic [NVIOL-1:0]            glob_hit;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  assign cmd = cmd_e'(cmd_i);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BW'(b));
    dtc_bank #(
      .TRCD(TRCD), .TRAS(TRAS), .TRAS_MAX(TRAS_MAX), .TRP(TRP), .TRC(TRC),
      .TWR(TWR), .TDAL(TDAL), .TRFC(TRFC), .BURST(BURST)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .act     (cmd == CMD_ACT && sel),
      .rd      (cmd == CMD_RD && sel),
      .wr      (cmd == CMD_WR && sel),
      .pre     ((cmd == CMD_PRE && sel) || cmd == CMD_PREA),
      .ref_all (cmd == CMD_REF),
      .mrs     (cmd == CMD_MRS),
      .ap      (ap_i),
      .state_o (bank_state_o[2*b +: 2]),
      .hit_o   (bank_hit[b])
    );
  end

  dtc_global #(
    .TRRD(TRRD), .TMRD(TMRD), .TCDLR(TCDLR), .BURST(BURST), .TREFI(TREFI)
  ) u_global (
    .clk   (clk),
    .rst_n (rst_q_n),
    .cmd   (cmd),
    .hit_o (glob_hit)
  );

  dtc_flags #(
    .NBANK(NBANK), .BW(BW)
  ) u_flags (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .bank_hit    (bank_hit),
    .glob_hit    (glob_hit),
    .cmd_bank    (bank_i),
    .viol_o      (viol_o),
    .viol_bank_o (viol_bank_o)
  );

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker
  import dtc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2,
  parameter int TRRD  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          cmd_i,
  input logic [BW-1:0]       bank_i,
  input logic [2*NBANK-1:0]  bank_state_o,
  input logic [NVIOL-1:0]    viol_o,
  input logic [NVIOL*BW-1:0] viol_bank_o
);

  localparam int SW = $clog2(TRRD + 1);

  logic [SW-1:0] since_act_q;

  // independent count of cycles since the last activate, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_act_q <= SW'(TRRD);
    else if (cmd_i == 3'd1)             since_act_q <= SW'(1);
    else if (since_act_q < SW'(TRRD))   since_act_q <= since_act_q + 1'b1;
  end

  for (genvar k = 0; k < NVIOL; k++) begin : g_k
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o[k] |=> viol_o[k]);
    a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o[k] |=> $stable(viol_bank_o[BW*k +: BW]));
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    a_r1_state_code: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state_o[2*b +: 2] != 2'd3);
    a_r1_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state_o[2*b +: 2] == 2'd0) && !(cmd_i == 3'd1 && bank_i == BW'(b)) &&
      (cmd_i != 3'd6) |=> bank_state_o[2*b +: 2] == 2'd0);
  end

  a_r3_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd2 || cmd_i == 3'd3) && (bank_state_o[2*bank_i +: 2] == 2'd0)
    |=> viol_o[V_PROTO]);

  a_r10_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1) && (since_act_q < SW'(TRRD)) |=> viol_o[V_RRD]);

endmodule

bind dram_timing_checker dtc_checker #(
  .NBANK(NBANK), .BW(BW), .TRRD(TRRD)
) u_dtc_checker (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .cmd_i        (cmd_i),
  .bank_i       (bank_i),
  .bank_state_o (bank_state_o),
  .viol_o       (viol_o),
  .viol_bank_o  (viol_bank_o)
);

// File: tb/dram_timing_checker_bench.sv
module dram_timing_checker_bench;

  localparam int CLK_P = 10;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, PREA = 3'd5, REF = 3'd6, MRS = 3'd7;

  logic        clk;
  logic        rst_n;
  logic [2:0]  cmd_i;
  logic [1:0]  bank_i;
  logic        ap_i;
  logic [7:0]  bank_state_o;
  logic [12:0] viol_o;
  logic [25:0] viol_bank_o;

  int  n_chk;
  int  n_err;
  bit  done;

  dram_timing_checker #(
    .TRC(18), .TRAS_MAX(40), .TREFI(200)
  ) u_dram_timing_checker (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .ap_i(ap_i),
    .bank_state_o(bank_state_o), .viol_o(viol_o), .viol_bank_o(viol_bank_o)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    cmd_i  = NOP;
    bank_i = '0;
    ap_i   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] c, input int b, input logic a);
    cmd_i  = c;
    bank_i = 2'(b);
    ap_i   = a;
    @(negedge clk);
    cmd_i = NOP;
    ap_i  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int vb(input int k);
    return int'(viol_bank_o[2*k +: 2]);
  endfunction

  function automatic int st(input int b);
    return int'(bank_state_o[2*b +: 2]);
  endfunction

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;

    // R14: reset state
    do_reset();
    chk("R14", "bank_state", int'(bank_state_o), 0);
    chk("R14", "viol", int'(viol_o), 0);
    chk("R14", "viol_bank", int'(viol_bank_o), 0);

    // R2: fully legal sequence raises nothing
    do_reset();
    issue(ACT, 0, 0); idle(4);
    issue(WR, 0, 0);  idle(4);
    issue(PRE, 0, 0); idle(4);
    issue(REF, 0, 0); idle(16);
    issue(ACT, 1, 0);
    chk("R2", "legal seq viol", int'(viol_o), 0);

    // R1: state after activate and precharge recovery length
    do_reset();
    issue(ACT, 0, 0);
    chk("R1", "open after act", st(0), 1);
    idle(9);
    issue(PRE, 0, 0);
    for (int k = 1; k <= 6; k++) begin
      chk("R1", $sformatf("state k=%0d", k), st(0), (k < 5) ? 2 : 0);
      idle(1);
    end

    // R4: activate to column command sweep
    for (int k = 1; k <= 7; k++) begin
      do_reset();
      issue(ACT, k % 4, 0); idle(k - 1);
      issue(RD, k % 4, 0);
      chk("R4", $sformatf("rcd k=%0d", k), int'(viol_o[1]), (k < 5) ? 1 : 0);
      if (k < 5) chk("R4", "rcd bank", vb(1), k % 4);
    end

    // R5: minimum row open time
    for (int k = 1; k <= 12; k++) begin
      do_reset();
      issue(ACT, 1, 0); idle(k - 1);
      issue(PRE, 1, 0);
      chk("R5", $sformatf("ras min k=%0d", k), int'(viol_o[2]), (k < 10) ? 1 : 0);
    end

    // R5: maximum row open time
    do_reset();
    issue(ACT, 2, 0); idle(40);
    chk("R5", "ras max before", int'(viol_o[8]), 0);
    idle(1);
    chk("R5", "ras max after", int'(viol_o[8]), 1);
    chk("R5", "ras max bank", vb(8), 2);

    // R6: precharge recovery
    for (int k = 1; k <= 7; k++) begin
      do_reset();
      issue(ACT, 3, 0); idle(9);
      issue(PRE, 3, 0); idle(k - 1);
      issue(ACT, 3, 0);
      chk("R6", $sformatf("rp k=%0d", k), int'(viol_o[3]), (k < 5) ? 1 : 0);
    end

    // R6: activate cycle time, separated from precharge recovery
    for (int k = 5; k <= 10; k++) begin
      do_reset();
      issue(ACT, 0, 0); idle(9);
      issue(PRE, 0, 0); idle(k - 1);
      issue(ACT, 0, 0);
      chk("R6", $sformatf("rc k=%0d", k), int'(viol_o[4]), (10 + k < 18) ? 1 : 0);
      chk("R6", "rp clean", int'(viol_o[3]), 0);
    end

    // R7: write recovery before normal precharge
    for (int k = 1; k <= 7; k++) begin
      do_reset();
      issue(ACT, 0, 0); idle(9);
      issue(WR, 0, 0);  idle(k - 1);
      issue(PRE, 0, 0);
      chk("R7", $sformatf("wr k=%0d", k), int'(viol_o[5]), (k < 5) ? 1 : 0);
    end

    // R8: write with auto-precharge
    for (int k = 8; k <= 12; k++) begin
      do_reset();
      issue(ACT, 1, 0); idle(4);
      issue(WR, 1, 1);
      chk("R8", "recovering after ap write", st(1), 2);
      idle(k - 1);
      issue(ACT, 1, 0);
      chk("R8", $sformatf("dal k=%0d", k), int'(viol_o[6]), (k < 10) ? 1 : 0);
    end

    // R9: refresh cycle time
    for (int k = 15; k <= 19; k++) begin
      do_reset();
      issue(REF, 0, 0); idle(k - 1);
      issue(ACT, 2, 0);
      chk("R9", $sformatf("rfc k=%0d", k), int'(viol_o[7]), (k < 17) ? 1 : 0);
    end
    do_reset();
    issue(REF, 0, 0); idle(2);
    issue(MRS, 0, 0);
    chk("R9", "mode write in refresh", int'(viol_o[7]), 1);
    chk("R11", "no mrd from refresh", int'(viol_o[10]), 0);

    // R10: activate to activate, different banks
    for (int k = 1; k <= 3; k++) begin
      do_reset();
      issue(ACT, 0, 0); idle(k - 1);
      issue(ACT, 1, 0);
      chk("R10", $sformatf("rrd k=%0d", k), int'(viol_o[9]), (k < 2) ? 1 : 0);
      if (k < 2) chk("R10", "rrd bank", vb(9), 1);
    end

    // R11: mode write settle time
    for (int k = 1; k <= 3; k++) begin
      do_reset();
      issue(MRS, 0, 0); idle(k - 1);
      issue(ACT, 0, 0);
      chk("R11", $sformatf("mrd k=%0d", k), int'(viol_o[10]), (k < 2) ? 1 : 0);
    end

    // R12: write to read gap
    for (int k = 1; k <= 6; k++) begin
      do_reset();
      issue(ACT, 0, 0); idle(1);
      issue(ACT, 1, 0); idle(4);
      issue(WR, 0, 0);  idle(k - 1);
      issue(RD, 1, 0);
      chk("R12", $sformatf("wtr k=%0d", k), int'(viol_o[11]), (k < 4) ? 1 : 0);
    end

    // R3 and R2: protocol errors, first offender kept
    do_reset();
    issue(RD, 2, 0);
    chk("R3", "read idle bank", int'(viol_o[0]), 1);
    chk("R3", "read idle bank id", vb(0), 2);
    issue(WR, 3, 0);
    chk("R2", "first bank kept", vb(0), 2);
    chk("R2", "flag kept", int'(viol_o[0]), 1);
    do_reset();
    issue(ACT, 1, 0); idle(9);
    issue(ACT, 1, 0);
    chk("R3", "activate open bank", int'(viol_o[0]), 1);
    do_reset();
    issue(ACT, 0, 0); idle(4);
    issue(REF, 0, 0);
    chk("R3", "refresh with open row", int'(viol_o[0]), 1);
    do_reset();
    issue(ACT, 3, 0); idle(4);
    issue(MRS, 0, 0);
    chk("R3", "mode write with open row", int'(viol_o[0]), 1);

    // R2: lowest bank recorded on simultaneous offence
    do_reset();
    issue(ACT, 2, 0); idle(1);
    issue(ACT, 1, 0); idle(1);
    issue(PREA, 0, 0);
    chk("R2", "prea ras flag", int'(viol_o[2]), 1);
    chk("R2", "lowest bank", vb(2), 1);

    // R13: refresh interval
    do_reset();
    idle(150);
    chk("R13", "no refi early", int'(viol_o[12]), 0);
    idle(100);
    chk("R13", "refi late", int'(viol_o[12]), 1);
    do_reset();
    for (int i = 0; i < 3; i++) begin
      idle(150);
      issue(REF, 0, 0);
    end
    chk("R13", "regular refresh", int'(viol_o[12]), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule